// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Late-Write Memory

This block is a synchronous single-port memory whose data bus never needs an idle cycle between a read and a write. Address and control are captured on a rising clock edge. Data for that access crosses the bus two active edges later: read data is launched from an output register, and write data is sampled from the input bus. Reads and writes therefore share one fixed latency and can be mixed in any order at full bus rate.

Sampled write data does not go straight into the array. It enters a two-entry posted-write buffer, and a buffer entry reaches the array only when two further writes have arrived behind it. A read that hits a buffered address is served from the buffer. Lanes are merged per byte, and the younger entry takes priority over the older one. The word has four 9-bit lanes with active-low byte enables. Three chip enables select the device, and an active-low clock enable stalls the whole pipeline. An unregistered output enable gates the drivers, and a sleep input first tri-states the outputs and then drains the pipeline.

The tristate bus is split into `din`, `dout` and a drive-enable `dout_en`. The depth is a parameter.

Top module: `zt_sram`

## Requirements
- R1: A read whose address is sampled on an active edge (cen_n low, not powered down) is returned on `dout` after the second active edge that follows. After that edge `dout_en` is high while `oe_n` is low and `sleep` is low.
- R2: The write data for an address sampled on an active edge is taken from `din` at the second active edge that follows.
- R3: Reads and writes may alternate on consecutive active edges with no idle cycle. A read always returns the most recently written value of every byte, including writes still held in the posted-write buffer. When both buffer entries hit, the younger entry wins per byte.
- R4: Byte enable `bw_n[i]` low writes bits 9*i+8 down to 9*i of the word. Any combination of lanes may be written, and the unselected lanes keep their contents.
- R5: A write with all four `bw_n` bits high changes no stored byte, and `dout_en` is low in its data cycle.
- R6: A cycle in which `ce1_n` is high, `ce2` is low or `ce3_n` is high performs no access, and `dout_en` is low in its data cycle.
- R7: An edge with `cen_n` high advances nothing. Queued accesses are delayed by one active edge, and `dout` and the drive state keep their previous values.
- R8: `oe_n` acts on `dout_en` in the same cycle, with no register between them.
- R9: `dout_en` is low in every cycle in which `sleep` is high. After `sleep` has been sampled high on two edges, each further edge with the count saturated discards every queued access and ignores the inputs. Stored data, including buffered writes, is kept.
- R10: While `rst_n` is low and after its release, `dout_en` is low, no access is queued and the write buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Clock enable, low to advance, high to stall |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Low for write, high for read |
| bw_n | input | LANES | Per-lane write enables, active low |
| addr | input | AW | Word address |
| din | input | DW | Write data, sampled two active edges after its address |
| oe_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Low-power request |
| dout | output | DW | Read data register |
| dout_en | output | 1 | Drive enable for dout |

## Verification
The embedded assertions check, on every clock, the rules that hold from one edge to the next. A stall leaves the output register and its drive state unchanged. A deselected cycle enters no access into the pipeline. A read leaving the second stage sets the output valid. Power-down empties both stages and the output. Whether a read returns the correct merged bytes cannot be seen locally. That covers hits on one or both buffer entries, partial writes, NOPs, and data retained across sleep. Only the bench's behavioural memory model can show these, by comparing `dout` and `dout_en` on every cycle across directed and random sequences.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  input  logic             oe_n,
  input  logic             sleep,
  output logic [DW-1:0]    dout,
  output logic             dout_en
);

  logic [1:0] scnt;
  wire pd  = (scnt == 2'd2);
  wire go  = !cen_n && !pd;
  wire sel = !ce1_n && ce2 && !ce3_n;

  logic             s1_v, s1_we, s2_v, s2_we;
  logic [AW-1:0]    s1_a, s2_a;
  logic [LANES-1:0] s1_be, s2_be;

  logic [1:0]       wb_v;
  logic [AW-1:0]    wb_a  [2];
  logic [LANES-1:0] wb_be [2];
  logic [DW-1:0]    wb_d  [2];

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_word, dout_q;
  logic          rd_v;

  wire push   = go && s2_v && s2_we;
  wire commit = push && wb_v[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      scnt <= 2'd0;
    else if (!sleep) scnt <= 2'd0;
    else if (!pd)    scnt <= scnt + 2'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_v <= 1'b0; s1_we <= 1'b0; s1_a <= '0; s1_be <= '0;
      s2_v <= 1'b0; s2_we <= 1'b0; s2_a <= '0; s2_be <= '0;
    end else if (pd) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else if (go) begin
      s1_v  <= sel;
      s1_we <= !we_n;
      s1_a  <= addr;
      s1_be <= ~bw_n;
      s2_v  <= s1_v;
      s2_we <= s1_we;
      s2_a  <= s1_a;
      s2_be <= s1_be;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wb_v <= 2'b00;
      for (int i = 0; i < 2; i++) begin
        wb_a[i] <= '0; wb_be[i] <= '0; wb_d[i] <= '0;
      end
    end else if (push) begin
      wb_v     <= {wb_v[0], 1'b1};
      wb_a[1]  <= wb_a[0];
      wb_be[1] <= wb_be[0];
      wb_d[1]  <= wb_d[0];
      wb_a[0]  <= s2_a;
      wb_be[0] <= s2_be;
      wb_d[0]  <= din;
    end

  always_ff @(posedge clk)
    if (commit)
      for (int g = 0; g < LANES; g++)
        if (wb_be[1][g])
          mem[wb_a[1]][g*LANE_W +: LANE_W] <= wb_d[1][g*LANE_W +: LANE_W];

  always_comb begin
    rd_word = mem[s2_a];
    for (int e = 1; e >= 0; e--)
      if (wb_v[e] && wb_a[e] == s2_a)
        for (int g = 0; g < LANES; g++)
          if (wb_be[e][g])
            rd_word[g*LANE_W +: LANE_W] = wb_d[e][g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_v   <= 1'b0;
      dout_q <= '0;
    end else if (pd) begin
      rd_v <= 1'b0;
    end else if (go) begin
      rd_v <= s2_v && !s2_we;
      if (s2_v && !s2_we) dout_q <= rd_word;
    end

  assign dout    = dout_q;
  assign dout_en = rd_v && !oe_n && !sleep;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cen_n && !pd) |=> ($stable(dout) && $stable(rd_v)));

  // R6
  unsel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !sel) |=> !s1_v);

  // R1
  read_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && s2_v && !s2_we) |=> rd_v);

  // R9
  pd_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (!s1_v && !s2_v && !rd_v));

endmodule

// File: tb/zt_sram_test.sv
`timescale 1ns/1ps
module zt_sram_test;
  localparam int AW = 10;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cen_n = 1'b1, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1, we_n = 1'b1;
  logic [3:0] bw_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic oe_n = 1'b1, sleep = 1'b0;
  logic [DW-1:0] dout;
  logic dout_en;

  always #10 clk = ~clk;

  zt_sram uut (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .we_n(we_n), .bw_n(bw_n), .addr(addr), .din(din), .oe_n(oe_n), .sleep(sleep),
    .dout(dout), .dout_en(dout_en)
  );

  typedef struct {int kind; int a; logic [3:0] bw;} mop_t;
  mop_t q[$];
  logic [DW-1:0] mm [1024];
  logic [DW-1:0] m_dout;
  logic m_rdv;
  int m_scnt;
  int vectors = 0, errors = 0;
  string cur_req = "R10";

  function automatic mop_t idle_op();
    mop_t o; o.kind = 0; o.a = 0; o.bw = 4'hF; return o;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); q.push_back(idle_op()); q.push_back(idle_op());
      m_rdv = 1'b0; m_scnt = 0;
    end else begin
      if (m_scnt == 2) begin
        q.delete(); q.push_back(idle_op()); q.push_back(idle_op());
        m_rdv = 1'b0;
      end else if (!cen_n) begin
        mop_t o, p;
        o.a = int'(addr); o.bw = bw_n;
        o.kind = (ce1_n || !ce2 || ce3_n) ? 0 : (we_n ? 1 : 2);
        q.push_back(o);
        p = q.pop_front();
        if (p.kind == 1) begin
          m_dout = mm[p.a]; m_rdv = 1'b1;
        end else begin
          m_rdv = 1'b0;
          if (p.kind == 2)
            for (int i = 0; i < 4; i++)
              if (!p.bw[i]) mm[p.a][i*9 +: 9] = din[i*9 +: 9];
        end
      end
      if (!sleep) m_scnt = 0;
      else if (m_scnt < 2) m_scnt = m_scnt + 1;
    end
  end

  task automatic compare();
    logic exp_en;
    exp_en = m_rdv && !oe_n && !sleep;
    vectors++;
    if (dout_en !== exp_en) begin
      errors++;
      $display("FAIL %s: dout_en=%0b expected %0b at %0t", cur_req, dout_en, exp_en, $time);
    end
    if (exp_en && !$isunknown(m_dout)) begin
      vectors++;
      if (dout !== m_dout) begin
        errors++;
        $display("FAIL %s: dout=%h expected %h at %0t", cur_req, dout, m_dout, $time);
      end
    end
  endtask

  task automatic cyc(input logic c, input logic e1, input logic e2, input logic e3,
                     input logic w, input logic [3:0] b, input int a,
                     input logic o, input logic s);
    @(negedge clk);
    compare();
    cen_n = c; ce1_n = e1; ce2 = e2; ce3_n = e3; we_n = w; bw_n = b;
    addr = AW'(a); oe_n = o; sleep = s;
    din = {$urandom, $urandom};
  endtask

  task automatic rd(input int a);        cyc(0, 0, 1, 0, 1, 4'hF, a, 0, 0); endtask
  task automatic wr(input int a, input logic [3:0] b); cyc(0, 0, 1, 0, 0, b, a, 0, 0); endtask
  task automatic stall();               cyc(1, 0, 1, 0, 1, 4'hF, 0, 0, 0); endtask
  task automatic desel(input int k);
    if (k == 0) cyc(0, 1, 1, 0, 1, 4'hF, 1, 0, 0);
    else if (k == 1) cyc(0, 0, 0, 0, 1, 4'hF, 1, 0, 0);
    else cyc(0, 0, 1, 1, 1, 4'hF, 1, 0, 0);
  endtask
  task automatic flush(); for (int i = 0; i < 3; i++) desel(0); endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mm[i] = 'x;
    // R10: reset state
    cur_req = "R10";
    repeat (3) cyc(1, 1, 0, 1, 1, 4'hF, 0, 0, 0);
    rst_n = 1'b1;
    repeat (3) desel(0);

    // R4: fill 16 words, then partial lane writes
    cur_req = "R4";
    for (int a = 0; a < 16; a++) wr(a, 4'h0);
    wr(3, 4'hE); wr(4, 4'hD); wr(5, 4'hB); wr(6, 4'h7); wr(7, 4'h5); wr(8, 4'hA);
    flush();
    for (int a = 0; a < 16; a++) rd(a);
    flush();

    // R1 / R2: back-to-back reads, then write followed directly by a read
    cur_req = "R1";
    rd(9); rd(10); rd(11); flush();
    cur_req = "R2";
    wr(12, 4'h0); rd(12); rd(12); flush();

    // R3: alternating traffic and double buffer hits with per-byte merge
    cur_req = "R3";
    wr(2, 4'h0); wr(2, 4'hC); rd(2); rd(2); flush();
    wr(1, 4'h3); rd(1); wr(1, 4'h6); rd(1); wr(0, 4'h0); rd(1); rd(0); flush();
    for (int i = 0; i < 20; i++) begin wr(i % 4, 4'(i)); rd((i + 1) % 4); end
    flush();

    // R5: NOP write leaves contents and bus untouched
    cur_req = "R5";
    wr(13, 4'hF); rd(13); wr(13, 4'hF); wr(13, 4'hF); rd(13); flush();

    // R6: each enable deselects on its own
    cur_req = "R6";
    desel(0); desel(1); desel(2); rd(14); desel(1); rd(14); flush();

    // R7: stalls between and inside accesses
    cur_req = "R7";
    rd(5); stall(); stall(); rd(6); stall(); wr(6, 4'h0); stall(); rd(6); stall(); stall(); flush();

    // R8: output enable toggles without a clock
    cur_req = "R8";
    rd(7); rd(7); rd(7);
    cyc(1, 0, 1, 0, 1, 4'hF, 0, 1, 0);
    #3 compare();
    oe_n = 1'b0; #3 compare();
    oe_n = 1'b1; #3 compare();
    cyc(1, 0, 1, 0, 1, 4'hF, 0, 0, 0);
    flush();

    // R9: short sleep, then long sleep with accesses in flight
    cur_req = "R9";
    rd(8); cyc(0, 0, 1, 0, 1, 4'hF, 9, 0, 1); rd(10); flush();
    wr(11, 4'h0); wr(11, 4'hE);
    rd(11); cyc(0, 0, 1, 0, 0, 4'h0, 11, 0, 1);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, 4'h0, 11, 0, 1);
    rd(11); rd(11); flush();

    // R3: random mix of everything
    cur_req = "R3";
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 19);
      int a = $urandom_range(0, 15);
      if (r < 7) rd(a);
      else if (r < 13) wr(a, 4'($urandom));
      else if (r < 15) stall();
      else if (r < 16) desel($urandom_range(0, 2));
      else if (r < 17) cyc(0, 0, 1, 0, 1, 4'hF, a, 1, 0);
      else if (r < 18) cyc(0, 0, 1, 0, 1, 4'hF, a, 0, 1);
      else rd(a);
    end
    flush();
    @(negedge clk); compare();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule